// File: doc/BRIEF.md
# Region-Based Data Prefetch Engine

This block is a prefetch controller for a data cache. Software sets up a small table of address regions, and each region has its own stride. The block watches every demand load. When a load falls inside an enabled region, the block adds that region's stride to the load address and aligns the result down to a cache-line boundary. The line is then offered to the cache refill side as a prefetch request. The goal is to have the data on chip before later loads reach it, so that those loads do not wait on memory.

Each candidate line is first checked against the cache tags through a single-cycle probe. A candidate is dropped if the line is already cached or already waiting in the request queue. The queue holds four pending requests. When it is full, new candidates are thrown away, and the demand stream is never stalled. Software owns the region table completely: a region changes only when software writes it. Any write to a region's bounds or stride takes that region out of service until software enables it again.

Top module: `rgn_prefetch`

## Requirements
- R1: The block has four independent regions. Each region has a start address, an end address, a stride and an enable bit. A region register is written with `cfg_we`, using `cfg_idx` to pick the region and `cfg_field` to pick the register: 0 is start, 1 is end, 2 is stride, and 3 is control, whose bit 0 is the enable.
- R2: A write to the start, end or stride of a region clears that region's enable bit. Only a control write can set the enable bit, and it sets it to `cfg_wdata[0]`.
- R3: A snooped address matches a region when the region is enabled and start <= address < end. If several regions match, the lowest-numbered one is used. A write in the same cycle as a snoop does not affect that snoop; the snoop is matched against the old register values.
- R4: The target line is (address + stride) with bits [5:0] cleared (64-byte lines). The candidate is dropped if the 32-bit addition carries out, or if the line is not below the matched region's end address.
- R5: The cycle after the snoop, the candidate appears on `probe_addr` with `probe_valid` high. If `probe_hit` is high in that cycle, the candidate is dropped.
- R6: A candidate whose line equals an entry already in the queue is dropped. This includes the head entry, even in a cycle where the head is being accepted.
- R7: The queue holds at most four requests and is first in, first out. A candidate is discarded if four requests are pending at that clock edge, even when the head leaves on the same edge. The snoop input never stalls.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays unchanged on the next cycle.
- R9: After reset, no region is enabled, the queue is empty and `probe_valid` is low.
- R10: When the queue is empty, a surviving candidate shows on `pf_valid`/`pf_addr` at the second rising edge after the snoop was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_idx | input | 2 | Region number for the write |
| cfg_field | input | 2 | Register select: 0 start, 1 end, 2 stride, 3 control |
| cfg_wdata | input | 32 | Write data |
| snoop_valid | input | 1 | A demand load is present |
| snoop_addr | input | 32 | Byte address of the demand load |
| probe_valid | output | 1 | Tag probe request |
| probe_addr | output | 32 | Line address being probed |
| probe_hit | input | 1 | Line is present in the cache (same cycle) |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Refill side accepts the request |
| pf_addr | output | 32 | Line address to prefetch |

## Verification
The hardest case to reach is a candidate that arrives at the probe while the queue is exactly full, at the same moment the refill side takes the head, or while that same line sits at the head. The stimulus holds `pf_ready` low for long stretches so the queue fills with distinct lines. It then releases `pf_ready` for single cycles while back-to-back snoops keep the probe stage busy. A randomised phase after that mixes ready gaps, cached-line sets and register rewrites, and a behavioural queue model checks every cycle.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
  localparam int unsigned PF_AW = 32;
  typedef logic [PF_AW-1:0] addr_t;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_STRIDE = 2'd2,
    FLD_CTRL   = 2'd3
  } fld_e;

  // Returns {carry, aligned line} of base + step, line size 2**off_w bytes.
  function automatic logic [PF_AW:0] step_line(input addr_t base, input addr_t step,
                                               input int unsigned off_w);
    logic [PF_AW:0] sum;
    addr_t          mask;
    sum  = {1'b0, base} + {1'b0, step};
    mask = ~((addr_t'(1) << off_w) - addr_t'(1));
    return {sum[PF_AW], sum[PF_AW-1:0] & mask};
  endfunction
endpackage

// File: rtl/pf_region_tbl.sv
`timescale 1ns/1ps
module pf_region_tbl
  import pf_pkg::*;
#(
  parameter int unsigned NUM_RGN = 4,
  localparam int unsigned IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  fld_e             cfg_field,
  input  addr_t            cfg_wdata,
  output addr_t            rgn_start  [NUM_RGN],
  output addr_t            rgn_end    [NUM_RGN],
  output addr_t            rgn_stride [NUM_RGN],
  output logic             rgn_en     [NUM_RGN]
);
  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    logic sel;
    assign sel = cfg_we && (cfg_idx == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rgn_start[r]  <= '0;
        rgn_end[r]    <= '0;
        rgn_stride[r] <= '0;
        rgn_en[r]     <= 1'b0;
      end else if (sel) begin
        case (cfg_field)
          FLD_START:  begin rgn_start[r]  <= cfg_wdata; rgn_en[r] <= 1'b0; end
          FLD_END:    begin rgn_end[r]    <= cfg_wdata; rgn_en[r] <= 1'b0; end
          FLD_STRIDE: begin rgn_stride[r] <= cfg_wdata; rgn_en[r] <= 1'b0; end
          default:    rgn_en[r] <= cfg_wdata[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/pf_target_gen.sv
`timescale 1ns/1ps
module pf_target_gen
  import pf_pkg::*;
#(
  parameter int unsigned NUM_RGN    = 4,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES)
) (
  input  logic  snoop_valid,
  input  addr_t snoop_addr,
  input  addr_t rgn_start  [NUM_RGN],
  input  addr_t rgn_end    [NUM_RGN],
  input  addr_t rgn_stride [NUM_RGN],
  input  logic  rgn_en     [NUM_RGN],
  output logic  cand_ok,
  output addr_t cand_line
);
  logic           any_hit;
  addr_t          sel_stride;
  addr_t          sel_end;
  logic [PF_AW:0] stepped;

  // Scan from the top so the lowest-numbered matching region is kept last.
  always_comb begin
    any_hit    = 1'b0;
    sel_stride = '0;
    sel_end    = '0;
    for (int r = NUM_RGN - 1; r >= 0; r--) begin
      if (rgn_en[r] && (snoop_addr >= rgn_start[r]) && (snoop_addr < rgn_end[r])) begin
        any_hit    = 1'b1;
        sel_stride = rgn_stride[r];
        sel_end    = rgn_end[r];
      end
    end
    stepped   = step_line(snoop_addr, sel_stride, OFF_W);
    cand_line = stepped[PF_AW-1:0];
    cand_ok   = snoop_valid && any_hit && !stepped[PF_AW] && (cand_line < sel_end);
  end
endmodule

// File: rtl/pf_req_fifo.sv
`timescale 1ns/1ps
module pf_req_fifo
  import pf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  addr_t            push_line,
  input  logic             pop,
  input  addr_t            cmp_line,
  output logic             cmp_match,
  output logic             full,
  output logic             not_empty,
  output addr_t            head_line,
  output logic [CNT_W-1:0] count
);
  addr_t            slot [DEPTH];
  logic [IDX_W-1:0] wr_idx;

  assign full      = (count == CNT_W'(DEPTH));
  assign not_empty = (count != '0);
  assign head_line = slot[0];
  assign wr_idx    = count[IDX_W-1:0] - IDX_W'(pop);

  always_comb begin
    cmp_match = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if ((CNT_W'(i) < count) && (slot[i] == cmp_line)) cmp_match = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (pop)
        for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
      if (push) slot[wr_idx] <= push_line;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/rgn_prefetch.sv
`timescale 1ns/1ps
module rgn_prefetch
  import pf_pkg::*;
#(
  parameter int unsigned NUM_RGN    = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned DEPTH      = 4,
  localparam int unsigned IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_field,
  input  logic [31:0]      cfg_wdata,
  input  logic             snoop_valid,
  input  logic [31:0]      snoop_addr,
  output logic             probe_valid,
  output logic [31:0]      probe_addr,
  input  logic             probe_hit,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [31:0]      pf_addr
);
  addr_t            rgn_start  [NUM_RGN];
  addr_t            rgn_end    [NUM_RGN];
  addr_t            rgn_stride [NUM_RGN];
  logic             rgn_en     [NUM_RGN];
  logic [NUM_RGN-1:0] en_vec;
  logic             cand_ok;
  addr_t            cand_line;
  logic             stg_v;
  addr_t            stg_line;
  logic             dup_hit;
  logic             q_full;
  logic [CNT_W-1:0] q_count;
  // Named events for the checker.
  logic             push_evt;
  logic             pop_evt;

  pf_region_tbl #(.NUM_RGN(NUM_RGN)) u_tbl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(fld_e'(cfg_field)), .cfg_wdata(cfg_wdata),
    .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_stride(rgn_stride), .rgn_en(rgn_en)
  );

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_en
    assign en_vec[r] = rgn_en[r];
  end

  pf_target_gen #(.NUM_RGN(NUM_RGN), .LINE_BYTES(LINE_BYTES)) u_tgt (
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_stride(rgn_stride), .rgn_en(rgn_en),
    .cand_ok(cand_ok), .cand_line(cand_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v    <= 1'b0;
      stg_line <= '0;
    end else begin
      stg_v    <= cand_ok;
      stg_line <= cand_line;
    end
  end

  assign probe_valid = stg_v;
  assign probe_addr  = stg_line;
  assign pop_evt     = pf_valid && pf_ready;
  assign push_evt    = stg_v && !probe_hit && !dup_hit && !q_full;

  pf_req_fifo #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_line(stg_line), .pop(pop_evt),
    .cmp_line(stg_line), .cmp_match(dup_hit), .full(q_full), .not_empty(pf_valid),
    .head_line(pf_addr), .count(q_count)
  );
endmodule

// File: rtl/pf_checker.sv
`timescale 1ns/1ps
module pf_checker #(
  parameter int unsigned NUM_RGN = 4,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned OFF_W   = 6,
  localparam int unsigned IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic [1:0]         cfg_field,
  input logic [NUM_RGN-1:0] en_vec,
  input logic               probe_valid,
  input logic [31:0]        probe_addr,
  input logic               probe_hit,
  input logic               push_evt,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [31:0]        pf_addr,
  input logic [CNT_W-1:0]   q_count
);
  p_cfg_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field != 2'd3) |=> !en_vec[$past(cfg_idx)]);

  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[OFF_W-1:0] == '0));

  p_hit_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_hit) |-> !push_evt);

  p_nodup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && pf_valid) |-> (probe_addr != pf_addr));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && q_count == '0) |=> (pf_valid && pf_addr == $past(probe_addr)));
endmodule

bind rgn_prefetch pf_checker #(
  .NUM_RGN(NUM_RGN), .DEPTH(DEPTH), .OFF_W($clog2(LINE_BYTES))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
  .en_vec(en_vec), .probe_valid(probe_valid), .probe_addr(probe_addr),
  .probe_hit(probe_hit), .push_evt(push_evt), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_addr(pf_addr), .q_count(q_count)
);

// File: tb/rgn_prefetch_tb.sv
`timescale 1ns/1ps
module rgn_prefetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic        probe_hit;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;
  logic [31:0] hot [4];

  int    vecs = 0;
  int    errs = 0;
  string tag  = "R9 reset";

  // behavioural reference
  logic [31:0] m_lo [4];
  logic [31:0] m_hi [4];
  logic [31:0] m_st [4];
  bit          m_on [4];
  bit          m_cv = 0;
  logic [31:0] m_ca = '0;
  logic [31:0] m_q [$];

  always #5 clk = ~clk;

  assign probe_hit = probe_valid && (probe_addr == hot[0] || probe_addr == hot[1] ||
                                     probe_addr == hot[2] || probe_addr == hot[3]);

  rgn_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit cached(input logic [31:0] a);
    foreach (hot[i]) if (hot[i] == a) return 1;
    return 0;
  endfunction

  // Advance the reference by one clock using the inputs now applied.
  task automatic model_step();
    bit          pop, push, dup, found, nv;
    logic [31:0] na;
    longint unsigned s;
    pop  = (m_q.size() > 0) && pf_ready;
    push = 0;
    if (m_cv) begin
      dup = 0;
      foreach (m_q[i]) if (m_q[i] == m_ca) dup = 1;
      push = !cached(m_ca) && !dup && (m_q.size() < 4);
    end
    nv = 0; na = '0; found = 0;
    if (snoop_valid) begin
      for (int r = 0; r < 4; r++) begin
        if (!found && m_on[r] && snoop_addr >= m_lo[r] && snoop_addr < m_hi[r]) begin
          found = 1;
          s = longint'(snoop_addr) + longint'(m_st[r]);
          s = s - (s % 64);
          if (s < 64'h1_0000_0000 && s < longint'(m_hi[r])) begin
            nv = 1; na = s[31:0];
          end
        end
      end
    end
    if (cfg_we) begin
      case (cfg_field)
        2'd0: begin m_lo[cfg_idx] = cfg_wdata; m_on[cfg_idx] = 0; end
        2'd1: begin m_hi[cfg_idx] = cfg_wdata; m_on[cfg_idx] = 0; end
        2'd2: begin m_st[cfg_idx] = cfg_wdata; m_on[cfg_idx] = 0; end
        default: m_on[cfg_idx] = cfg_wdata[0];
      endcase
    end
    if (pop) void'(m_q.pop_front());
    if (push) m_q.push_back(m_ca);
    m_cv = nv; m_ca = na;
  endtask

  task automatic compare();
    bit ev;
    ev = m_q.size() > 0;
    chk(pf_valid == ev, "pf_valid", 32'(pf_valid), 32'(ev));
    if (ev) chk(pf_addr == m_q[0], "pf_addr", pf_addr, m_q[0]);
    chk(probe_valid == m_cv, "probe_valid (R5)", 32'(probe_valid), 32'(m_cv));
    if (m_cv) chk(probe_addr == m_ca, "probe_addr (R4)", probe_addr, m_ca);
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    cfg_we = 0;
    snoop_valid = 0;
  endtask

  task automatic wr(input int r, input int f, input logic [31:0] d);
    cfg_we = 1; cfg_idx = 2'(r); cfg_field = 2'(f); cfg_wdata = d;
    step();
  endtask

  task automatic snoop(input logic [31:0] a);
    snoop_valid = 1; snoop_addr = a;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      hot[i] = 32'hFFFF_FFC0; m_lo[i] = 0; m_hi[i] = 0; m_st[i] = 0; m_on[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();
    chk(!pf_valid && !probe_valid, "R9 idle after reset", 32'(pf_valid), 0);

    tag = "R1 programming";
    wr(0, 0, 32'h1000); wr(0, 1, 32'h2000); wr(0, 2, 32'h80);
    tag = "R9 disabled region";
    snoop(32'h1000);
    chk(!probe_valid, "R9 no candidate while disabled", 32'(probe_valid), 0);
    tag = "R1 enable";
    wr(0, 3, 32'h1);
    tag = "R10 latency";
    snoop(32'h1010);
    chk(probe_valid && probe_addr == 32'h1080, "R5 probe one cycle after", probe_addr, 32'h1080);
    idle(1);
    chk(pf_valid && pf_addr == 32'h1080, "R10 request after two edges", pf_addr, 32'h1080);
    idle(2);

    tag = "R3 priority";
    wr(1, 0, 32'h1800); wr(1, 1, 32'h3000); wr(1, 2, 32'h400); wr(1, 3, 32'h1);
    snoop(32'h1900);
    chk(probe_addr == 32'h1980, "R3 lowest region wins", probe_addr, 32'h1980);
    snoop(32'h2100);
    snoop(32'h2000);
    chk(probe_addr == 32'h2400, "R3 end is exclusive", probe_addr, 32'h2400);
    idle(3);

    tag = "R4 end bound";
    snoop(32'h1FC0);
    chk(!probe_valid, "R4 target past end dropped", 32'(probe_valid), 0);
    wr(3, 0, 32'hFFFF_F000); wr(3, 1, 32'hFFFF_FFFF); wr(3, 2, 32'h2000); wr(3, 3, 1);
    snoop(32'hFFFF_F100);
    chk(!probe_valid, "R4 carry-out dropped", 32'(probe_valid), 0);
    idle(2);

    tag = "R5 tag hit";
    hot[0] = 32'h1100;
    snoop(32'h1080);
    idle(1);
    chk(!pf_valid, "R5 cached line not requested", 32'(pf_valid), 0);
    hot[0] = 32'hFFFF_FFC0;

    tag = "R6 duplicate";
    pf_ready = 0;
    snoop(32'h1010); snoop(32'h1020); idle(2);
    pf_ready = 1; idle(1);
    chk(!pf_valid, "R6 only one copy queued", 32'(pf_valid), 0);

    tag = "R7 full";
    pf_ready = 0;
    for (int i = 0; i < 6; i++) snoop(32'h1000 + 32'(i) * 32'h40);
    idle(1);
    tag = "R8 hold";
    idle(3);
    chk(pf_valid && pf_addr == 32'h1080, "R8 head held", pf_addr, 32'h1080);
    tag = "R7 pop at full";
    snoop(32'h1400);
    pf_ready = 1; step(); pf_ready = 0; step();
    tag = "R6 head duplicate";
    snoop(32'h1040);
    pf_ready = 1; step();
    pf_ready = 0; idle(1);
    pf_ready = 1; idle(6);
    chk(!pf_valid, "R7 drained", 32'(pf_valid), 0);

    tag = "R2 rewrite";
    wr(0, 0, 32'h1000);
    wr(1, 2, 32'h400);
    snoop(32'h1100);
    chk(!probe_valid, "R2 rewrite disables region", 32'(probe_valid), 0);
    wr(0, 3, 1);
    tag = "R3 write during snoop";
    cfg_we = 1; cfg_idx = 0; cfg_field = 2'd3; cfg_wdata = 0;
    snoop_valid = 1; snoop_addr = 32'h1100;
    step();
    chk(probe_valid && probe_addr == 32'h1180, "R3 old registers used", probe_addr, 32'h1180);
    idle(3);

    tag = "R8 random";
    for (int n = 0; n < 1500; n++) begin
      pf_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) hot[$urandom_range(0, 3)] = 32'($urandom_range(0, 255)) * 64;
      if ($urandom_range(0, 39) == 0) begin
        cfg_we = 1; cfg_idx = 2'($urandom_range(0, 3)); cfg_field = 2'($urandom_range(0, 3));
        cfg_wdata = (cfg_field == 2'd3) ? 32'h1 : 32'($urandom_range(0, 16'h4000));
      end
      snoop_valid = $urandom_range(0, 1) == 1;
      snoop_addr  = 32'($urandom_range(0, 16'h4000));
      step();
    end
    pf_ready = 1; idle(8);

    summary();
    $finish;
  end
endmodule